// File: doc/BRIEF.md
# Reduced-Resolution Motion-Compensated Prediction Interpolator

This block forms motion-compensated prediction samples straight from anchor pictures that are held in memory at reduced resolution. A large picture is kept at one third or one half of its width and at half of its height. The motion vectors still refer to the full-resolution grid. For each output sample the block takes a small window of stored reference samples and computes three steps in one pass. First it expands the window back to the full grid by sample-and-hold. Then it applies bilinear half-pel interpolation, chosen by the full-precision motion vector. Last it averages the result back onto the reduced grid. Because the downsample is an average and the upsample is a hold, a zero vector returns the stored sample unchanged.

Each input vector carries a window of six reference samples: three stored lines of two columns each. With the window come the full-resolution motion vector, the horizontal scale (2 or 3) and the field/frame choice of the encoder for the current macroblock. Frame processing takes vertical neighbours from adjacent stored lines. Field processing takes them only from lines of the same parity. When no choice is supplied, the block uses field processing. An external address generator positions the window: the window's first column is reduced column floor(floor(mv_x/2)/S), where S is the horizontal scale, and its first line follows the same rule vertically. Fetching, addressing and residual addition are done elsewhere. The block accepts one vector per cycle and returns one sample two cycles later.

Top module: `rr_pred_interp`

## Requirements
- R1: While rst_n is low at a rising edge, the next cycle shows out_valid = 0 and out_sample = 0.
- R2: A vector accepted with in_valid = 1 at one rising edge produces out_valid = 1 with its sample after the second rising edge. With in_valid = 0 there is no output two cycles later. Vectors may arrive on every cycle.
- R3: With mv_x = 0 and mv_y = 0, out_sample equals window sample line 0 column 0 (ref_win bits 7:0), for both scales and both modes.
- R4: hscale_three = 1 selects a horizontal scale of 3, and hscale_three = 0 selects 2. The cell averaged per output is S columns by 2 lines of full-resolution samples.
- R5: The horizontal phase is floor(mv_x/2) mod S. The vertical phase is floor(mv_y/2) mod 2. Both use floor for negative vectors, so vectors that differ by 2*S horizontally give the same result for the same window.
- R6: Bit 0 of mv_x and bit 0 of mv_y select half-pel interpolation at full resolution. A two-tap result is (a+b+1)>>1. A four-tap result is (a+b+c+d+2)>>2.
- R7: The S*2 interpolated samples are averaged with halves rounded up: (sum+2)>>2 for S = 2, and (sum+3)/6 for S = 3.
- R8: In frame mode, full-resolution lines 0..1 map to window line 0 and lines 2..3 map to window line 1. In field mode they map to window lines 0 and 2, so window line 1 has no effect.
- R9: Frame mode applies only when mb_mode_valid = 1 and mb_mode_frame = 1. Otherwise field mode applies.
- R10: out_sample is 8 bits and stays between the smallest and the largest window sample used. A window of all 255 gives 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Vector present this cycle |
| hscale_three | input | 1 | 1: horizontal scale 3, 0: scale 2 |
| mb_mode_valid | input | 1 | Encoder field/frame choice supplied |
| mb_mode_frame | input | 1 | Choice is frame (when supplied) |
| mv_x | input | 12 | Signed horizontal vector, half-pel units, full resolution |
| mv_y | input | 12 | Signed vertical vector, half-pel units, full resolution |
| ref_win | input | 48 | Six 8-bit samples; sample (line l, column c) at bits (2l+c)*8 +: 8 |
| out_valid | output | 1 | Prediction sample present |
| out_sample | output | 8 | Prediction sample |

## Verification
Two functions overlap in every cycle of a stream. While one vector's cell average is being registered at the output, the next vector's window, phase and mode are being captured and interpolated. A wrong pipeline alignment would therefore pair one vector's average with another's scale or mode. This is provoked by streaming several hundred vectors back to back that sweep positive and negative vectors, both scales and all three mode-select combinations. Each output two cycles after its input is judged against a full-resolution reference computed in the bench.

// File: rtl/rrpi_pkg.sv
// Package: shared constants and types for the reduced-resolution
// prediction interpolator. Assumes a fixed vertical scale of two and a
// reference window of three stored lines by two columns.
package rrpi_pkg;
    localparam int VSCALE     = 2;
    localparam int MAX_HSCALE = 3;
    localparam int WIN_COLS   = 2;
    localparam int WIN_ROWS   = 3;
    localparam int NUM_TAPS   = WIN_COLS * WIN_ROWS;
    localparam int NUM_POS    = MAX_HSCALE * VSCALE;

    typedef enum logic {
        MODE_FIELD = 1'b0,
        MODE_FRAME = 1'b1
    } row_mode_e;
endpackage

// File: rtl/rrpi_phase.sv
// Module: rrpi_phase
// Turns a full-precision motion vector into the phase of the vector inside
// one reduced cell, plus the two half-pel flags. Assumes the window has
// already been positioned at floor(floor(mv/2)/scale). Purely combinational.
module rrpi_phase #(
    parameter int MV_W = 12
) (
    input  logic signed [MV_W-1:0] mv_x,
    input  logic signed [MV_W-1:0] mv_y,
    input  logic                   hscale_three,
    output logic [1:0]             ph_x,
    output logic                   hh_x,
    output logic                   ph_y,
    output logic                   hh_y
);
    logic signed [MV_W-1:0] int_x;
    logic signed [MV_W-1:0] rem3;
    logic                   mvy_hi_unused;

    // Horizontal phase: floor(mv_x/2) taken modulo the horizontal scale.
    always_comb begin
        int_x = mv_x >>> 1;
        rem3  = int_x % $signed(MV_W'(3));
        if (rem3 < 0) begin
            rem3 = rem3 + $signed(MV_W'(3));
        end
        ph_x = hscale_three ? rem3[1:0] : {1'b0, int_x[0]};
        hh_x = mv_x[0];
    end

    // Vertical phase: bit 0 of floor(mv_y/2) is bit 1 of the vector.
    assign ph_y          = mv_y[1];
    assign hh_y          = mv_y[0];
    assign mvy_hi_unused = ^mv_y[MV_W-1:2];
endmodule

// File: rtl/rrpi_tap.sv
// Module: rrpi_tap
// Computes one full-resolution predicted sample at position (POS_X, POS_Y)
// inside the output cell. It holds the window samples onto the full grid
// (sample-and-hold) and applies bilinear half-pel interpolation with
// round-half-up. Assumes phases lie inside one cell. Combinational.
module rrpi_tap #(
    parameter int PIX_W = 8,
    parameter int POS_X = 0,
    parameter int POS_Y = 0
) (
    input  logic [rrpi_pkg::NUM_TAPS*PIX_W-1:0] win,
    input  logic                                hscale_three,
    input  rrpi_pkg::row_mode_e                 mode,
    input  logic [1:0]                          ph_x,
    input  logic                                hh_x,
    input  logic                                ph_y,
    input  logic                                hh_y,
    output logic [PIX_W-1:0]                    p
);
    import rrpi_pkg::*;

    logic [2:0]       xa, xb;
    logic [1:0]       ya, yb;
    logic             col_a, col_b;
    logic [1:0]       row_a, row_b;
    logic [PIX_W-1:0] s00, s01, s10, s11;
    logic [PIX_W+1:0] sum4;
    logic [PIX_W:0]   sum_h, sum_v;

    // Read one window sample by stored line and column.
    function automatic logic [PIX_W-1:0] pick(input logic [PIX_W*NUM_TAPS-1:0] w,
                                              input logic [1:0] row, input logic col);
        int idx;
        idx = int'(row) * WIN_COLS + int'(col);
        return w[idx*PIX_W +: PIX_W];
    endfunction

    // Map full-grid coordinates onto window columns and lines.
    always_comb begin
        xa    = 3'(POS_X) + {1'b0, ph_x};
        xb    = xa + {2'b00, hh_x};
        ya    = 2'(POS_Y) + {1'b0, ph_y};
        yb    = ya + {1'b0, hh_y};
        col_a = hscale_three ? (xa >= 3'd3) : (xa >= 3'd2);
        col_b = hscale_three ? (xb >= 3'd3) : (xb >= 3'd2);
        row_a = (mode == MODE_FIELD) ? {ya[1], 1'b0} : {1'b0, ya[1]};
        row_b = (mode == MODE_FIELD) ? {yb[1], 1'b0} : {1'b0, yb[1]};
    end

    // Fetch the four taps and apply the half-pel rule selected by the flags.
    always_comb begin
        s00   = pick(win, row_a, col_a);
        s01   = pick(win, row_a, col_b);
        s10   = pick(win, row_b, col_a);
        s11   = pick(win, row_b, col_b);
        sum4  = {2'b00, s00} + {2'b00, s01} + {2'b00, s10} + {2'b00, s11}
              + (PIX_W+2)'(2);
        sum_h = {1'b0, s00} + {1'b0, s01} + (PIX_W+1)'(1);
        sum_v = {1'b0, s00} + {1'b0, s10} + (PIX_W+1)'(1);
        if (hh_x && hh_y) begin
            p = sum4[PIX_W+1:2];
        end else if (hh_x) begin
            p = sum_h[PIX_W:1];
        end else if (hh_y) begin
            p = sum_v[PIX_W:1];
        end else begin
            p = s00;
        end
    end
endmodule

// File: rtl/rrpi_cell_avg.sv
// Module: rrpi_cell_avg
// Averages the interpolated samples of one output cell back onto the reduced
// grid with round-half-up, and registers the result. Positions are indexed
// line*MAX_HSCALE + column; the third column is skipped at scale two.
module rrpi_cell_avg #(
    parameter int PIX_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 en,
    input  logic                                 hscale_three,
    input  logic [rrpi_pkg::NUM_POS*PIX_W-1:0]   taps,
    output logic                                 out_valid,
    output logic [PIX_W-1:0]                     out_sample
);
    import rrpi_pkg::*;

    localparam int SUM_W = PIX_W + $clog2(NUM_POS + 1);

    logic [SUM_W-1:0] sum, q6, q4;
    logic [PIX_W-1:0] mn, mx;

    // Sum the used positions and track their range for the bound check.
    always_comb begin
        sum = '0;
        mn  = '1;
        mx  = '0;
        for (int i = 0; i < NUM_POS; i++) begin
            if (hscale_three || (i % MAX_HSCALE) < 2) begin
                sum = sum + SUM_W'(taps[i*PIX_W +: PIX_W]);
                if (taps[i*PIX_W +: PIX_W] < mn) mn = taps[i*PIX_W +: PIX_W];
                if (taps[i*PIX_W +: PIX_W] > mx) mx = taps[i*PIX_W +: PIX_W];
            end
        end
        q6 = (sum + SUM_W'(3)) / SUM_W'(6);
        q4 = (sum + SUM_W'(2)) >> 2;
    end

    // Register the rounded average and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid  <= en;
            out_sample <= en ? (hscale_three ? q6[PIX_W-1:0] : q4[PIX_W-1:0]) : out_sample;
        end
    end

    // R7 / R10: a rounded average never leaves the range of its inputs.
    assert_avg_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (out_sample >= $past(mn) && out_sample <= $past(mx)))
        else $error("cell average outside input range");
endmodule

// File: rtl/rr_pred_interp.sv
// Module: rr_pred_interp (top)
// Reduced-resolution prediction interpolator: captures one window, vector
// and mode per cycle (stage 1), forms the full-grid interpolated samples of
// the output cell and averages them (stage 2). Latency two cycles, one
// result per cycle. Assumes the window is already positioned by the caller.
module rr_pred_interp #(
    parameter int PIX_W = 8,
    parameter int MV_W  = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic                                hscale_three,
    input  logic                                mb_mode_valid,
    input  logic                                mb_mode_frame,
    input  logic signed [MV_W-1:0]              mv_x,
    input  logic signed [MV_W-1:0]              mv_y,
    input  logic [rrpi_pkg::NUM_TAPS*PIX_W-1:0] ref_win,
    output logic                                out_valid,
    output logic [PIX_W-1:0]                    out_sample
);
    import rrpi_pkg::*;

    logic                          vld_q, hs3_q;
    row_mode_e                     mode_q;
    logic signed [MV_W-1:0]        mvx_q, mvy_q;
    logic [NUM_TAPS*PIX_W-1:0]     win_q;
    logic [1:0]                    ph_x;
    logic                          hh_x, ph_y, hh_y;
    logic [NUM_POS*PIX_W-1:0]      taps;

    // Stage 1: capture the vector; a missing mode choice means field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            hs3_q  <= 1'b0;
            mode_q <= MODE_FIELD;
            mvx_q  <= '0;
            mvy_q  <= '0;
            win_q  <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                hs3_q  <= hscale_three;
                mode_q <= (mb_mode_valid && mb_mode_frame) ? MODE_FRAME : MODE_FIELD;
                mvx_q  <= mv_x;
                mvy_q  <= mv_y;
                win_q  <= ref_win;
            end
        end
    end

    rrpi_phase #(.MV_W(MV_W)) u_phase (
        .mv_x(mvx_q), .mv_y(mvy_q), .hscale_three(hs3_q),
        .ph_x(ph_x), .hh_x(hh_x), .ph_y(ph_y), .hh_y(hh_y)
    );

    // One interpolator per full-grid position of the output cell.
    for (genvar gy = 0; gy < VSCALE; gy++) begin : g_line
        for (genvar gx = 0; gx < MAX_HSCALE; gx++) begin : g_col
            rrpi_tap #(.PIX_W(PIX_W), .POS_X(gx), .POS_Y(gy)) u_tap (
                .win(win_q), .hscale_three(hs3_q), .mode(mode_q),
                .ph_x(ph_x), .hh_x(hh_x), .ph_y(ph_y), .hh_y(hh_y),
                .p(taps[(gy*MAX_HSCALE+gx)*PIX_W +: PIX_W])
            );
        end
    end

    rrpi_cell_avg #(.PIX_W(PIX_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .en(vld_q), .hscale_three(hs3_q),
        .taps(taps), .out_valid(out_valid), .out_sample(out_sample)
    );

    // R1: reset leaves the output idle and cleared.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sample == '0))
        else $error("output not cleared by reset");

    // R2: every accepted vector yields a result two cycles later.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid)
        else $error("result missing two cycles after input");

    // R2: no input, no result two cycles later.
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid)
        else $error("result without input");

    // R3: a zero vector returns the stored sample unchanged.
    assert_zero_mv_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mv_x == '0 && mv_y == '0) |-> ##2
            (out_sample == $past(ref_win[PIX_W-1:0], 2)))
        else $error("zero vector altered the sample");

    // R5: the decoded horizontal phase stays inside one reduced cell.
    assert_phase_in_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (ph_x < (hs3_q ? 2'd3 : 2'd2)))
        else $error("horizontal phase outside cell");
endmodule

// File: tb/rr_pred_interp_test.sv
module rr_pred_interp_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 15;

    localparam logic [47:0] WA = 48'hE6C8_8264_280A; // 10,40 / 100,130 / 200,230
    localparam logic [47:0] WB = 48'h0000_0000_0201; // 1,2 / 0,0 / 0,0
    localparam logic [47:0] WC = 48'hFFFF_FFFF_FFFF;

    // Table: scale3, mode valid, mode frame, mv_x, mv_y, window, expected
    localparam int T_HS[NT]  = '{1, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam int T_MV[NT]  = '{1, 0, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1, 1};
    localparam int T_MF[NT]  = '{1, 0, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 0};
    localparam int T_X[NT]   = '{0, 0, 1, 2, 6, -2, 2, 0, 0, 0, 0, 1, 2, 1, 0};
    localparam int T_Y[NT]   = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 2, 1, 0, 1, 2};
    localparam int T_W[NT]   = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0};
    localparam int T_E[NT]   = '{10, 10, 15, 20, 10, 30, 25, 33, 58, 58, 55, 40, 2, 255, 105};
    // Row tags: 0 R3, 1 R3, 2 R6, 3 R4, 4 R5, 5 R5, 6 R4, 7 R6, 8 R8,
    //           9 R9, 10 R8, 11 R6, 12 R7, 13 R10, 14 R8
    localparam int T_R[NT]   = '{3, 3, 6, 4, 5, 5, 4, 6, 8, 9, 8, 6, 7, 10, 8};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              hscale_three = 1'b0;
    logic              mb_mode_valid = 1'b0;
    logic              mb_mode_frame = 1'b0;
    logic signed [11:0] mv_x = '0;
    logic signed [11:0] mv_y = '0;
    logic [47:0]       ref_win = '0;
    logic              out_valid;
    logic [7:0]        out_sample;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int exp_arr[0:1023];

    rr_pred_interp uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hscale_three(hscale_three),
        .mb_mode_valid(mb_mode_valid), .mb_mode_frame(mb_mode_frame),
        .mv_x(mv_x), .mv_y(mv_y), .ref_win(ref_win),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: hold onto the full grid, interpolate, average back.
    function automatic int model(input logic [47:0] w, input int sh, input bit field,
                                 input int mvx, input int mvy);
        int ix, rx, hx, ry, hy, sum, n;
        ix = mvx >>> 1;
        rx = ((ix % sh) + sh) % sh;
        hx = mvx & 1;
        ry = (mvy >>> 1) & 1;
        hy = mvy & 1;
        sum = 0;
        n = 2 * sh;
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < sh; k++) begin
                int v[4];
                int xs[2];
                int ys[2];
                int p;
                xs[0] = k + rx; xs[1] = k + rx + hx;
                ys[0] = m + ry; ys[1] = m + ry + hy;
                for (int j = 0; j < 2; j++) begin
                    for (int i = 0; i < 2; i++) begin
                        int ln;
                        ln = field ? 2 * (ys[j] / 2) : ys[j] / 2;
                        v[j*2+i] = int'(w[(ln*2 + xs[i]/sh)*8 +: 8]);
                    end
                end
                if (hx != 0 && hy != 0) p = (v[0] + v[1] + v[2] + v[3] + 2) / 4;
                else if (hx != 0)       p = (v[0] + v[1] + 1) / 2;
                else if (hy != 0)       p = (v[0] + v[2] + 1) / 2;
                else                    p = v[0];
                sum += p;
            end
        end
        return (sum + n / 2) / n;
    endfunction

    task automatic drive(input int hs, input int mval, input int mfrm,
                         input int x, input int y, input logic [47:0] w);
        in_valid      = 1'b1;
        hscale_three  = hs[0];
        mb_mode_valid = mval[0];
        mb_mode_frame = mfrm[0];
        mv_x          = 12'(x);
        mv_y          = 12'(y);
        ref_win       = w;
    endtask

    task automatic single(input string req, input int hs, input int mval, input int mfrm,
                          input int x, input int y, input logic [47:0] w, input int exp);
        @(negedge clk);
        drive(hs, mval, mfrm, x, y, w);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " no early result"}, int'(out_valid), 0);
        @(negedge clk);
        check({req, " valid"}, int'(out_valid), 1);
        check(req, int'(out_sample), exp);
    endtask

    initial begin
        // R1: reset with activity on the inputs
        drive(1, 1, 1, 3, 3, WA);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 sample after reset", int'(out_sample), 0);

        // Table walk
        for (int t = 0; t < NT; t++) begin
            logic [47:0] w;
            w = (T_W[t] == 0) ? WA : (T_W[t] == 1) ? WB : WC;
            single($sformatf("R%0d table row %0d", T_R[t], t),
                   T_HS[t], T_MV[t], T_MF[t], T_X[t], T_Y[t], w, T_E[t]);
        end

        // R8: field mode ignores window line 1
        single("R8 field ignores line 1", 0, 1, 0, 0, 1, 48'hE6C8_0000_280A, 58);
        // R9: unsupplied choice with frame bit set still means field
        single("R9 default field", 0, 0, 1, 0, 2, WA, 105);
        // R5: negative vector, scale two
        single("R5 negative mv_x scale 2", 0, 1, 1, -2, 0, WA, 25);

        // R2: back-to-back stream, every output two cycles after its input
        begin
            int nv = 0;
            logic [47:0] ws = 48'h47A0_055A_E911;
            for (int hs = 0; hs < 2; hs++)
                for (int md = 0; md < 3; md++)
                    for (int x = -7; x <= 7; x++)
                        for (int y = -3; y <= 3; y++) nv++;
            nv = 0;
            for (int hs = 0; hs < 2; hs++) begin
                for (int md = 0; md < 3; md++) begin
                    for (int x = -7; x <= 7; x++) begin
                        for (int y = -3; y <= 3; y++) begin
                            @(negedge clk);
                            if (nv >= 2) begin
                                check("R2 stream valid", int'(out_valid), 1);
                                check($sformatf("R2 stream vector %0d", nv - 2),
                                      int'(out_sample), exp_arr[nv-2]);
                            end
                            drive(hs, (md == 0) ? 0 : 1, (md == 2) ? 1 : 0, x, y, ws);
                            exp_arr[nv] = model(ws, hs ? 3 : 2, md != 2, x, y);
                            nv++;
                        end
                    end
                end
            end
            for (int t = 0; t < 2; t++) begin
                @(negedge clk);
                in_valid = 1'b0;
                check("R2 stream tail valid", int'(out_valid), 1);
                check("R2 stream tail", int'(out_sample), exp_arr[nv-2+t]);
            end
            @(negedge clk);
            check("R2 idle after stream", int'(out_valid), 0);
            @(negedge clk);
            check("R2 still idle", int'(out_valid), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule